// File: doc/BRIEF.md
# CAN Bus Wake-Up Pattern Detector

This block is the digital control logic for a set of independent CAN transceiver channels (two by default). Each channel receives a digital bus-state level (1 = dominant, 0 = recessive) from its analog front end and an active-low standby input. Each channel drives one receive-data output, `rxd`. The bus level may change at any time relative to the clock, so it passes through a two-flop synchronizer before the rest of the logic uses it.

When a channel's standby input is high, the channel is in Normal mode and `rxd` mirrors the bus: low for dominant, high for recessive. When the standby input is low, the channel is in Standby mode and a timed pattern filter watches the bus. The filter accepts a wake-up only after it sees a dominant phase, then a recessive phase, then a second dominant phase, each lasting at least a minimum time. The whole pattern must also finish within a timeout. When the pattern is accepted, `rxd` goes low and stays low as a wake-up request. The request does not change the mode. Only raising the standby input returns the channel to Normal mode, and that also clears the request.

All durations are counted in clock cycles and set by parameters: `T_DOM` is the minimum dominant phase, `T_REC` is the minimum recessive phase, and `T_WAKE_TO` is the completion window. `T_DOM` must be at least 2.

Top module: `can_wake_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every `rxd` bit is 1, and every wake-up filter is idle.
- R2: With `stby_n[i]` = 1, `rxd[i]` equals the inverse of `bus_dom[i]` as it was two clock edges earlier (1 = dominant gives `rxd` 0).
- R3: With `stby_n[i]` = 0, `rxd[i]` stays 1 until a wake-up is accepted. On each entry into Standby, the filter starts in idle and `rxd[i]` is 1 from the first Standby cycle.
- R4: In Standby, the filter accepts a wake-up, and drives `rxd[i]` to 0, after this sequence on the synchronized bus: at least `T_DOM` dominant cycles, then at least `T_REC` recessive cycles, then `T_DOM` dominant cycles.
- R5: A dominant phase that ends before `T_DOM` cycles, or a recessive phase that ends before `T_REC` cycles, abandons the attempt. A new attempt starts only on a recessive-to-dominant transition of the synchronized bus, so a short recessive gap restarts the count at its closing dominant edge.
- R6: An attempt is accepted only if its total length is at most `T_WAKE_TO` cycles. The length is counted from its first dominant cycle to its final required dominant cycle. A longer attempt returns the filter to idle.
- R7: A bus held dominant for any length of time in Standby never produces a wake-up, including when it is already dominant as Standby is entered.
- R8: Once accepted, the wake-up request holds `rxd[i]` at 0 for as long as `stby_n[i]` stays 0, whatever the bus does. Raising `stby_n[i]` returns the channel to R2 behaviour and clears the request.
- R9: Channels are independent: the mode, bus activity and wake-up state of one channel never change the `rxd` of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_n | input | N_CH | Per-channel mode select, 1 = Normal, 0 = Standby (synchronous to clk) |
| bus_dom | input | N_CH | Per-channel bus level from the front end, 1 = dominant, 0 = recessive (asynchronous) |
| rxd | output | N_CH | Per-channel receive data in Normal mode; in Standby, 0 = wake-up request |

## Verification
The assertions take `stby_n` to be synchronous to the clock, since only `bus_dom` is synchronized. They also take reset to be held long enough to flush the synchronizer before the Normal-mode mirror property is checked. The bench therefore changes `stby_n` and `bus_dom` only on falling clock edges and holds reset for several cycles at the start. It sweeps phase lengths on each channel at, below and above every threshold and at the timeout boundary, while the other channel is held in a fixed Normal state.

// File: rtl/canwk_pkg.sv
package canwk_pkg;

    // Number of flops in the bus-level synchronizer.
    localparam int SYNC_STAGES = 2;

    // Wake-up filter progress through the three-phase pattern.
    typedef enum logic [2:0] {
        WK_IDLE = 3'd0,
        WK_DOM1 = 3'd1,
        WK_REC  = 3'd2,
        WK_DOM2 = 3'd3,
        WK_WOKE = 3'd4
    } wk_state_e;

    // Synchronized bus level together with its value one cycle earlier.
    typedef struct packed {
        logic dom;
        logic dom_prev;
    } bus_view_t;

    // A pattern attempt may start only on a recessive-to-dominant step.
    function automatic logic rise_to_dom(input bus_view_t b);
        return b.dom & ~b.dom_prev;
    endfunction

    // Output level: the bus mirror in Normal mode, the request flag in Standby.
    function automatic logic rxd_level(input logic normal, input logic dom,
                                       input logic woke);
        return normal ? ~dom : ~woke;
    endfunction

endpackage

// File: rtl/canwk_sync.sv
module canwk_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Each bit gets its own shift chain; reset value is recessive (0).
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/canwk_pattern_filter.sv
module canwk_pattern_filter
    import canwk_pkg::*;
#(
    parameter int T_DOM     = 3,
    parameter int T_REC     = 2,
    parameter int T_WAKE_TO = 10,
    localparam int CNT_W    = $clog2(T_WAKE_TO + 1)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  bus_view_t view,
    output logic      woke
);
    localparam logic [CNT_W-1:0] DOM_MIN  = CNT_W'(T_DOM);
    localparam logic [CNT_W-1:0] REC_MIN  = CNT_W'(T_REC);
    localparam logic [CNT_W-1:0] WIN_MAX  = CNT_W'(T_WAKE_TO);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    wk_state_e        state_q, state_d;
    logic [CNT_W-1:0] phase_q, phase_d;   // cycles in the current phase
    logic [CNT_W-1:0] total_q, total_d;   // cycles since the attempt began
    logic             start_edge;
    logic             expired;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == '1) ? v : v + CNT_ONE;
    endfunction

    assign start_edge = rise_to_dom(view);
    assign expired    = (total_q >= WIN_MAX);

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        total_d = total_q;
        if (!en) begin
            state_d = WK_IDLE;
            phase_d = '0;
            total_d = '0;
        end else begin
            unique case (state_q)
                WK_IDLE: begin
                    if (start_edge) begin
                        state_d = WK_DOM1;
                        phase_d = CNT_ONE;
                        total_d = CNT_ONE;
                    end
                end
                WK_DOM1: begin
                    if (expired) begin
                        state_d = WK_IDLE;
                        phase_d = '0;
                        total_d = '0;
                    end else if (view.dom) begin
                        phase_d = sat_inc(phase_q);
                        total_d = sat_inc(total_q);
                    end else if (phase_q >= DOM_MIN) begin
                        state_d = WK_REC;
                        phase_d = CNT_ONE;
                        total_d = sat_inc(total_q);
                    end else begin
                        state_d = WK_IDLE;
                        phase_d = '0;
                        total_d = '0;
                    end
                end
                WK_REC: begin
                    if (expired) begin
                        state_d = WK_IDLE;
                        phase_d = '0;
                        total_d = '0;
                    end else if (!view.dom) begin
                        phase_d = sat_inc(phase_q);
                        total_d = sat_inc(total_q);
                    end else if (phase_q >= REC_MIN) begin
                        state_d = WK_DOM2;
                        phase_d = CNT_ONE;
                        total_d = sat_inc(total_q);
                    end else begin
                        // Gap too short: this dominant edge opens a new attempt.
                        state_d = WK_DOM1;
                        phase_d = CNT_ONE;
                        total_d = CNT_ONE;
                    end
                end
                WK_DOM2: begin
                    if (expired) begin
                        state_d = WK_IDLE;
                        phase_d = '0;
                        total_d = '0;
                    end else if (view.dom) begin
                        if (sat_inc(phase_q) >= DOM_MIN) begin
                            state_d = WK_WOKE;
                        end else begin
                            phase_d = sat_inc(phase_q);
                            total_d = sat_inc(total_q);
                        end
                    end else begin
                        state_d = WK_IDLE;
                        phase_d = '0;
                        total_d = '0;
                    end
                end
                WK_WOKE: begin
                    state_d = WK_WOKE;
                end
                default: begin
                    state_d = WK_IDLE;
                    phase_d = '0;
                    total_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WK_IDLE;
            phase_q <= '0;
            total_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            total_q <= total_d;
        end
    end

    assign woke = (state_q == WK_WOKE);

endmodule

// File: rtl/canwk_channel.sv
module canwk_channel
    import canwk_pkg::*;
#(
    parameter int T_DOM     = 3,
    parameter int T_REC     = 2,
    parameter int T_WAKE_TO = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic stby_n,
    input  logic bus_dom,
    output logic rxd
);
    logic      bus_s;
    logic      bus_p;
    logic      normal_q;
    logic      woke;
    bus_view_t view;

    canwk_sync #(
        .STAGES(SYNC_STAGES),
        .WIDTH (1)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (bus_dom),
        .q  (bus_s)
    );

    // Previous synchronized level, for edge detection; mode register.
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_p    <= 1'b0;
            normal_q <= 1'b0;
        end else begin
            bus_p    <= bus_s;
            normal_q <= stby_n;
        end
    end

    assign view.dom      = bus_s;
    assign view.dom_prev = bus_p;

    canwk_pattern_filter #(
        .T_DOM    (T_DOM),
        .T_REC    (T_REC),
        .T_WAKE_TO(T_WAKE_TO)
    ) u_filter (
        .clk (clk),
        .rst (rst),
        .en  (~normal_q),
        .view(view),
        .woke(woke)
    );

    assign rxd = rxd_level(normal_q, bus_s, woke);

endmodule

// File: rtl/can_wake_ctrl.sv
module can_wake_ctrl #(
    parameter int N_CH      = 2,
    parameter int T_DOM     = 3,
    parameter int T_REC     = 2,
    parameter int T_WAKE_TO = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] stby_n,
    input  logic [N_CH-1:0] bus_dom,
    output logic [N_CH-1:0] rxd
);
    if (T_DOM < 2) begin : g_bad_tdom
        $error("T_DOM must be at least 2");
    end
    if (T_WAKE_TO < 2 * T_DOM + T_REC) begin : g_bad_window
        $error("T_WAKE_TO shorter than the minimum pattern");
    end

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        canwk_channel #(
            .T_DOM    (T_DOM),
            .T_REC    (T_REC),
            .T_WAKE_TO(T_WAKE_TO)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .stby_n (stby_n[c]),
            .bus_dom(bus_dom[c]),
            .rxd    (rxd[c])
        );
    end

endmodule

// File: rtl/canwk_chk.sv
module canwk_chk #(
    parameter int N_CH = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [N_CH-1:0] stby_n,
    input logic [N_CH-1:0] bus_dom,
    input logic [N_CH-1:0] rxd
);
    // R1: the cycle after a reset edge shows every output high.
    a_r1_reset_high: assert property (@(posedge clk) rst |=> (rxd == '1));

    for (genvar c = 0; c < N_CH; c++) begin : g_chk
        // R2: Normal mode mirrors the inverted bus with two edges of latency.
        a_r2_normal_mirror: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) && $past(stby_n[c]))
            |-> (rxd[c] == ~$past(bus_dom[c], 2)));

        // R3: the first Standby cycle starts with no request.
        a_r3_fresh_standby: assert property (@(posedge clk) disable iff (rst)
            ($past(stby_n[c]) && !stby_n[c]) |=> rxd[c]);

        // R8: an accepted request holds while Standby is kept.
        a_r8_request_holds: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(stby_n[c]) && !stby_n[c] && !rxd[c]) |=> !rxd[c]);
    end

endmodule

bind can_wake_ctrl canwk_chk #(.N_CH(N_CH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .stby_n (stby_n),
    .bus_dom(bus_dom),
    .rxd    (rxd)
);

// File: tb/sim_can_wake_ctrl.sv
module sim_can_wake_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int TD  = 3;
    localparam int TR  = 2;
    localparam int TO  = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] stby_n = '0;
    logic [NCH-1:0] bus_dom = '0;
    logic [NCH-1:0] rxd;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    can_wake_ctrl #(
        .N_CH(NCH), .T_DOM(TD), .T_REC(TR), .T_WAKE_TO(TO)
    ) u0 (
        .clk(clk), .rst(rst), .stby_n(stby_n), .bus_dom(bus_dom), .rxd(rxd)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One pattern attempt on channel ch; the other channel stays in Normal
    // with a dominant bus, so its rxd must read 0 throughout (R9).
    task automatic run_pattern(input int ch, input int d1, input int r, input int d2);
        int  oth = 1 - ch;
        bit  ok;
        string tag;
        stby_n[oth] = 1'b1; bus_dom[oth] = 1'b1;
        stby_n[ch] = 1'b1; bus_dom[ch] = 1'b0;
        tick(3);
        stby_n[ch] = 1'b0;
        tick(3);
        chk("R3 standby idle", rxd[ch], 1'b1);
        bus_dom[ch] = 1'b1; tick(d1);
        bus_dom[ch] = 1'b0; tick(r);
        bus_dom[ch] = 1'b1; tick(d2);
        bus_dom[ch] = 1'b0; tick(6);
        ok = (d1 >= TD) && (r >= TR) && (d2 >= TD) && (d1 + r + TD <= TO);
        if (d1 < TD || r < TR || d2 < TD) tag = "R5 short phase";
        else if (d1 + r + TD > TO)        tag = "R6 timeout";
        else                              tag = "R4 valid pattern";
        chk(tag, rxd[ch], ~ok);
        chk("R9 other channel", rxd[oth], 1'b0);
    endtask

    initial begin
        tick(4);
        chk("R1 reset ch0", rxd[0], 1'b1);
        chk("R1 reset ch1", rxd[1], 1'b1);
        rst = 1'b0;
        tick(1);
        chk("R1 after release", rxd[0] & rxd[1], 1'b1);

        // R2: Normal mode mirror over all bus combinations, plus latency.
        stby_n = 2'b11;
        for (int v = 0; v < 8; v++) begin
            bus_dom = v[1:0];
            tick(3);
            chk("R2 mirror ch0", rxd[0], ~v[0]);
            chk("R2 mirror ch1", rxd[1], ~v[1]);
        end
        bus_dom = 2'b00; tick(3);
        bus_dom = 2'b01; tick(1);
        chk("R2 latency one edge", rxd[0], 1'b1);
        tick(1);
        chk("R2 latency two edges", rxd[0], 1'b0);

        // R4/R5/R6/R9: phase-length sweep on each channel.
        for (int ch = 0; ch < NCH; ch++)
            for (int d1 = 1; d1 <= 5; d1++)
                for (int r = 1; r <= 4; r++)
                    for (int d2 = 1; d2 <= 5; d2++)
                        run_pattern(ch, d1, r, d2);

        // R7: bus dominant already when Standby begins, held long.
        stby_n = 2'b11; bus_dom = 2'b01; tick(4);
        stby_n[0] = 1'b0; tick(60);
        chk("R7 dominant at entry", rxd[0], 1'b1);
        // R7: dominant after a clean recessive edge, held past the window.
        bus_dom[0] = 1'b0; tick(4);
        bus_dom[0] = 1'b1; tick(60);
        chk("R7 stuck dominant", rxd[0], 1'b1);

        // R8: accept, then hold under bus activity, then release.
        bus_dom[0] = 1'b0; tick(4);
        bus_dom[0] = 1'b1; tick(TD);
        bus_dom[0] = 1'b0; tick(TR);
        bus_dom[0] = 1'b1; tick(TD);
        bus_dom[0] = 1'b0; tick(4);
        chk("R4 minimal pattern", rxd[0], 1'b0);
        for (int k = 0; k < 20; k++) begin
            bus_dom[0] = k[1];
            tick(1);
        end
        chk("R8 request holds", rxd[0], 1'b0);
        bus_dom[0] = 1'b0; stby_n[0] = 1'b1; tick(3);
        chk("R8 normal after release", rxd[0], 1'b1);
        bus_dom[0] = 1'b1; tick(3);
        chk("R8 normal mirrors bus", rxd[0], 1'b0);
        bus_dom[0] = 1'b0; tick(3);
        stby_n[0] = 1'b0; tick(1);
        chk("R3 fresh standby", rxd[0], 1'b1);
        tick(5);
        chk("R8 request cleared", rxd[0], 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule